// File: doc/BRIEF.md
# Read-Protection Flash Access Gate

This block sits in front of an embedded flash array and decides, in the same cycle as the request, whether a flash access may proceed. Each request carries its kind (code fetch, data read, write or erase), the bus master issuing it (CPU, debug, DMA or coprocessor) and a target sector. The gate combines the request with the live read-protection state, the per-sector write-lock vector supplied by the protection disable logic, and its own lock bits. From these it raises exactly one of two strobes: grant or deny. A denied request never reaches the array.

The gate owns three kinds of state. The first is a pair of fetch lock bits, one blocking instruction fetches and one blocking data reads. The second is a set of sticky per-master lock bits for debug, DMA and coprocessor traffic. The third is a debug shutoff latch. Reset sets both fetch lock bits. The boot-exit pulse releases them only when the device booted from internal program flash. Software can set any lock bit at any time, but it can clear one only while read protection is not active. When read protection is active, the gate also blocks every write and erase. When read protection is merely suspended, only sectors without their own write lock accept modification.

Top module: `rpg_gate`

## Requirements
- R1: After reset, both fetch lock bits read 1, all three master lock bits read 0 and the debug shutoff reads 0.
- R2: On a boot-exit pulse with `boot_src` = 0 (internal program flash), both fetch lock bits become 0 on the next edge. With `boot_src` = 1, 2 or 3 (internal or external RAM), they keep their value.
- R3: A software write (`cfg_we`) with a bit at 1 sets that fetch lock bit. A 0 clears it only if `rp_active` is 0, and otherwise leaves it unchanged.
- R4: The master lock bits (`mlock` bit 0 debug, bit 1 DMA, bit 2 coprocessor) follow the same rule: software sets them at any time and clears them only when `rp_active` is 0.
- R5: A code fetch (`req_kind` = 0) is denied exactly when `rp_active` and the code-fetch lock bit are both 1, apart from the debug rule of R9.
- R6: A data read (`req_kind` = 1) is denied when `rp_active` and the data-fetch lock bit are both 1, or when the requesting non-CPU master (`req_master` 1 debug, 2 DMA, 3 coprocessor) has its lock bit set.
- R7: While `rp_active` is 1, every write (`req_kind` = 2) and erase (`req_kind` = 3) is denied, for every sector.
- R8: While `rp_active` is 0, a write or erase is denied exactly when `sector_wp` has the target sector's bit at 1 or the requesting master's lock bit is set.
- R9: A boot-exit pulse while `rp_active` is 1 sets the debug shutoff, which holds until reset. While it is set, every request from the debug master is denied.
- R10: `grant` and `deny` are combinational in the request cycle. Exactly one of them is 1 when `req_valid` is 1, and both are 0 when it is 0.
- R11: When a boot exit and a software write fall in the same cycle, the boot release is applied first and the software write is then applied on top of it under the R3/R4 rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rp_active | input | 1 | Read protection installed and currently enforced |
| boot_exit | input | 1 | One-cycle pulse at boot program exit |
| boot_src | input | 2 | Boot source: 0 program flash, 1 internal RAM, 2/3 external RAM |
| sector_wp | input | SECTORS | Per-sector write-lock state, 1 = locked |
| cfg_we | input | 1 | Software write strobe for all lock bits |
| cfg_cfd | input | 1 | Written value of the code-fetch lock |
| cfg_dfd | input | 1 | Written value of the data-fetch lock |
| cfg_mlock | input | 3 | Written values of the master lock bits |
| req_valid | input | 1 | Access request present |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 erase |
| req_master | input | 2 | 0 CPU, 1 debug, 2 DMA, 3 coprocessor |
| req_sector | input | SECT_W | Target sector index |
| grant | output | 1 | Access allowed this cycle |
| deny | output | 1 | Access refused this cycle |
| cfd_q | output | 1 | Code-fetch lock bit |
| dfd_q | output | 1 | Data-fetch lock bit |
| mlock_q | output | 3 | Master lock bits |
| dbg_off | output | 1 | Debug shutoff latch |

## Verification
The boot-exit release and a software write to the lock bits can land on the same edge. The bench provokes this by pulsing `boot_exit` from program flash while `cfg_we` sets the code-fetch lock and writes 0 to the data-fetch lock with read protection active. It then expects the code-fetch lock set and the data-fetch lock clear. The same collision is repeated from a RAM boot with read protection suspended, where the software clear must win. Grant and deny are swept exhaustively over every lock-bit state, request kind, master, sector and protection level. The expected strobe is recomputed by a bench formula that is written differently from the RTL.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_ERASE = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    MST_CPU = 2'd0,
    MST_DBG = 2'd1,
    MST_DMA = 2'd2,
    MST_COP = 2'd3
  } master_e;

  localparam logic [1:0] BOOT_PFLASH = 2'd0;
  localparam int unsigned NUM_LOCKED_MASTERS = 3;

  // next value of a sticky lock bit: boot release first, then software
  function automatic logic lock_next(input logic cur, input logic boot_clr,
                                     input logic we, input logic wval,
                                     input logic clr_ok);
    logic after_boot;
    after_boot = boot_clr ? 1'b0 : cur;
    if (!we)        return after_boot;
    else if (wval)  return 1'b1;
    else if (clr_ok) return 1'b0;
    else            return after_boot;
  endfunction

  function automatic logic is_modify(input acc_kind_e k);
    return (k == ACC_WRITE) || (k == ACC_ERASE);
  endfunction
endpackage

// File: rtl/rpg_fetch_bits.sv
module rpg_fetch_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic boot_clr,
  input  logic clr_ok,
  input  logic sw_we,
  input  logic sw_cfd,
  input  logic sw_dfd,
  output logic cfd_q,
  output logic dfd_q
);
  import rpg_pkg::*;

  logic [1:0] bits_q;
  logic [1:0] sw_val;
  assign sw_val = {sw_dfd, sw_cfd};

  for (genvar i = 0; i < 2; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bits_q[i] <= 1'b1;
      else        bits_q[i] <= lock_next(bits_q[i], boot_clr, sw_we, sw_val[i], clr_ok);
    end

    AST_FETCH_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_ok && !boot_clr) |=> !$fell(bits_q[i])) else $error("fetch lock cleared"); // R3
  end

  assign cfd_q = bits_q[0];
  assign dfd_q = bits_q[1];
endmodule

// File: rtl/rpg_master_lock.sv
module rpg_master_lock #(
  parameter int unsigned NLOCK = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_ok,
  input  logic             sw_we,
  input  logic [NLOCK-1:0] sw_val,
  input  logic             boot_exit,
  input  logic             rp_active,
  output logic [NLOCK-1:0] lock_q,
  output logic             dbg_off_q
);
  import rpg_pkg::*;

  for (genvar m = 0; m < NLOCK; m++) begin : g_mst
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lock_q[m] <= 1'b0;
      else        lock_q[m] <= lock_next(lock_q[m], 1'b0, sw_we, sw_val[m], clr_ok);
    end

    AST_MLOCK_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_ok |=> !$fell(lock_q[m])) else $error("master lock cleared"); // R4
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       dbg_off_q <= 1'b0;
    else if (boot_exit && rp_active)  dbg_off_q <= 1'b1;
  end

  AST_DBG_OFF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_off_q |=> dbg_off_q) else $error("debug shutoff dropped"); // R9
endmodule

// File: rtl/rpg_decide.sv
module rpg_decide #(
  parameter int unsigned SECTORS = 16,
  parameter int unsigned NLOCK   = 3,
  localparam int unsigned SECT_W = (SECTORS > 1) ? $clog2(SECTORS) : 1
) (
  input  logic                rp_active,
  input  logic                cfd,
  input  logic                dfd,
  input  logic [NLOCK-1:0]    mlock,
  input  logic                dbg_off,
  input  logic [SECTORS-1:0]  sector_wp,
  input  logic                req_valid,
  input  rpg_pkg::acc_kind_e  kind,
  input  rpg_pkg::master_e    master,
  input  logic [SECT_W-1:0]   sector,
  output logic                fetch_blk,
  output logic                read_blk,
  output logic                modify_blk,
  output logic                master_blk,
  output logic                dbg_blk,
  output logic                grant,
  output logic                deny
);
  import rpg_pkg::*;

  logic blocked;

  always_comb begin
    master_blk = 1'b0;
    for (int m = 0; m < int'(NLOCK); m++)
      if (int'(master) == m + 1 && mlock[m]) master_blk = (kind != ACC_FETCH);
    fetch_blk  = (kind == ACC_FETCH) && rp_active && cfd;
    read_blk   = (kind == ACC_READ) && rp_active && dfd;
    modify_blk = is_modify(kind) && (rp_active || sector_wp[sector]);
    dbg_blk    = (master == MST_DBG) && dbg_off;
    blocked    = fetch_blk | read_blk | modify_blk | master_blk | dbg_blk;
    grant      = req_valid && !blocked;
    deny       = req_valid && blocked;
  end
endmodule

// File: rtl/rpg_gate.sv
module rpg_gate #(
  parameter int unsigned SECTORS = 16,
  localparam int unsigned SECT_W = (SECTORS > 1) ? $clog2(SECTORS) : 1,
  localparam int unsigned NLOCK  = rpg_pkg::NUM_LOCKED_MASTERS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rp_active,
  input  logic               boot_exit,
  input  logic [1:0]         boot_src,
  input  logic [SECTORS-1:0] sector_wp,
  input  logic               cfg_we,
  input  logic               cfg_cfd,
  input  logic               cfg_dfd,
  input  logic [NLOCK-1:0]   cfg_mlock,
  input  logic               req_valid,
  input  logic [1:0]         req_kind,
  input  logic [1:0]         req_master,
  input  logic [SECT_W-1:0]  req_sector,
  output logic               grant,
  output logic               deny,
  output logic               cfd_q,
  output logic               dfd_q,
  output logic [NLOCK-1:0]   mlock_q,
  output logic               dbg_off
);
  import rpg_pkg::*;

  logic boot_clr, clr_ok;
  logic fetch_blk, read_blk, modify_blk, master_blk, dbg_blk;

  assign boot_clr = boot_exit && (boot_src == BOOT_PFLASH);
  assign clr_ok   = !rp_active;

  rpg_fetch_bits u_fetch (
    .clk(clk), .rst_n(rst_n), .boot_clr(boot_clr), .clr_ok(clr_ok),
    .sw_we(cfg_we), .sw_cfd(cfg_cfd), .sw_dfd(cfg_dfd),
    .cfd_q(cfd_q), .dfd_q(dfd_q)
  );

  rpg_master_lock #(.NLOCK(NLOCK)) u_mlock (
    .clk(clk), .rst_n(rst_n), .clr_ok(clr_ok), .sw_we(cfg_we),
    .sw_val(cfg_mlock), .boot_exit(boot_exit), .rp_active(rp_active),
    .lock_q(mlock_q), .dbg_off_q(dbg_off)
  );

  rpg_decide #(.SECTORS(SECTORS), .NLOCK(NLOCK)) u_decide (
    .rp_active(rp_active), .cfd(cfd_q), .dfd(dfd_q), .mlock(mlock_q),
    .dbg_off(dbg_off), .sector_wp(sector_wp), .req_valid(req_valid),
    .kind(acc_kind_e'(req_kind)), .master(master_e'(req_master)),
    .sector(req_sector), .fetch_blk(fetch_blk), .read_blk(read_blk),
    .modify_blk(modify_blk), .master_blk(master_blk), .dbg_blk(dbg_blk),
    .grant(grant), .deny(deny)
  );

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && deny) && (req_valid == (grant || deny))) else $error("strobe clash"); // R10
  AST_GLOBAL_WRLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rp_active && req_kind[1]) |-> deny) else $error("write passed"); // R7
  AST_DBG_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && dbg_off && req_master == 2'd1) |-> !grant) else $error("debug passed"); // R9
  AST_BOOT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_clr && !cfg_we) |=> (!cfd_q && !dfd_q)) else $error("boot release lost"); // R2
  AST_FETCH_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd0 && req_master != 2'd1 && !(rp_active && cfd_q)) |-> grant)
    else $error("fetch wrongly denied"); // R5
endmodule

// File: tb/tb_rpg_gate.sv
module tb_rpg_gate;
  localparam int SECTORS = 16;
  localparam int SW = $clog2(SECTORS);

  logic clk = 1'b0, rst_n = 1'b0;
  logic rp_active = 0, boot_exit = 0, cfg_we = 0, cfg_cfd = 0, cfg_dfd = 0, req_valid = 0;
  logic [1:0] boot_src = 0, req_kind = 0, req_master = 0;
  logic [SECTORS-1:0] sector_wp = 0;
  logic [2:0] cfg_mlock = 0;
  logic [SW-1:0] req_sector = 0;
  logic grant, deny, cfd_q, dfd_q, dbg_off;
  logic [2:0] mlock_q;

  int errors = 0, checks = 0;
  bit done = 0;
  logic m_cfd, m_dfd, m_dbg;
  logic [2:0] m_ml;

  always #4 clk = ~clk;

  rpg_gate #(.SECTORS(SECTORS)) dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_regs(input string tag);
    chk({tag, " cfd"}, cfd_q, m_cfd);
    chk({tag, " dfd"}, dfd_q, m_dfd);
    chk({tag, " mlock"}, mlock_q, m_ml);
    chk({tag, " dbgoff"}, dbg_off, m_dbg);
  endtask

  // one clock with boot and/or software stimulus; model updated by the requirement rules
  task automatic cyc(input logic rpa, input logic bx, input logic [1:0] src, input logic we,
                     input logic wc, input logic wd, input logic [2:0] wm, input string tag);
    logic c0, d0;
    @(negedge clk);
    rp_active = rpa; boot_exit = bx; boot_src = src;
    cfg_we = we; cfg_cfd = wc; cfg_dfd = wd; cfg_mlock = wm;
    @(posedge clk);
    c0 = (bx && src == 2'd0) ? 1'b0 : m_cfd;
    d0 = (bx && src == 2'd0) ? 1'b0 : m_dfd;
    if (we) begin
      m_cfd = wc | (c0 & rpa);
      m_dfd = wd | (d0 & rpa);
      m_ml  = wm | (m_ml & {3{rpa}});
    end else begin
      m_cfd = c0; m_dfd = d0;
    end
    m_dbg = m_dbg | (bx & rpa);
    @(negedge clk);
    boot_exit = 0; cfg_we = 0;
    #1 chk_regs(tag);
  endtask

  task automatic sweep(input int phase);
    for (int st = 0; st < 32; st++) begin
      cyc(1'b0, 1'b0, 2'd0, 1'b1, st[0], st[1], st[4:2], "R3 R4 setup");
      sector_wp = 16'hB4E1 ^ (16'(st) * 16'h0421) ^ 16'(phase);
      for (int rpa = 0; rpa < 2; rpa++)
        for (int v = 0; v < 2; v++)
          for (int k = 0; k < 4; k++)
            for (int mst = 0; mst < 4; mst++)
              for (int sec = 0; sec < SECTORS; sec++) begin
                logic e;
                string tag;
                rp_active = rpa[0]; req_valid = v[0]; req_kind = k[1:0];
                req_master = mst[1:0]; req_sector = sec[SW-1:0];
                e = 1'b0;
                if (mst == 1 && m_dbg) e = 1'b1;
                if (k != 0 && mst != 0 && m_ml[mst-1]) e = 1'b1;
                case (k)
                  0: if (rpa == 1 && m_cfd) e = 1'b1;
                  1: if (rpa == 1 && m_dfd) e = 1'b1;
                  default: if (rpa == 1 || sector_wp[sec]) e = 1'b1;
                endcase
                case (k)
                  0: tag = "R5";
                  1: tag = "R6";
                  default: tag = (rpa == 1) ? "R7" : "R8";
                endcase
                if (phase == 1 && mst == 1) tag = {tag, " R9"};
                #1;
                chk({tag, " R10 grant"}, grant, v[0] & ~e);
                chk({tag, " R10 deny"}, deny, v[0] & e);
              end
      req_valid = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_cfd = 1; m_dfd = 1; m_ml = 0; m_dbg = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1 chk_regs("R1 reset");
    chk("R1 R10 grant idle", grant, 0);
    chk("R1 R10 deny idle", deny, 0);
    cyc(0, 1, 2'd1, 0, 0, 0, 3'b000, "R2 boot iram keeps");
    cyc(0, 1, 2'd2, 0, 0, 0, 3'b000, "R2 boot xram keeps");
    cyc(1, 0, 2'd0, 1, 0, 0, 3'b000, "R3 clear blocked");
    cyc(1, 0, 2'd0, 1, 0, 0, 3'b101, "R4 set while active");
    cyc(1, 0, 2'd0, 1, 0, 0, 3'b000, "R4 clear blocked");
    cyc(0, 0, 2'd0, 1, 0, 0, 3'b000, "R3 R4 clear allowed");
    cyc(0, 0, 2'd0, 1, 1, 1, 3'b000, "R3 set");
    cyc(0, 1, 2'd0, 0, 0, 0, 3'b000, "R2 boot flash clears");
    sweep(0);
    cyc(0, 0, 2'd0, 1, 1, 1, 3'b000, "R3 set again");
    cyc(1, 1, 2'd0, 1, 1, 0, 3'b000, "R11 collision flash");
    chk("R11 cfd wins", cfd_q, 1);
    chk("R11 dfd released", dfd_q, 0);
    chk("R9 dbg off set", dbg_off, 1);
    cyc(0, 0, 2'd0, 1, 1, 1, 3'b000, "R3 set again");
    cyc(0, 1, 2'd1, 1, 0, 1, 3'b000, "R11 collision ram");
    chk("R11 sw clear wins", cfd_q, 0);
    sweep(1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule